// File: doc/BRIEF.md
# Pin Interrupt Sense and Status Bank

This block turns the input pins of one bank into a single interrupt request. The bank has four ports of eight pins each. Every pin has its own sense mode, which is level-high, level-low, rising edge, falling edge or both edges. Every pin also has a sticky status bit and an enable bit. Each pin input is brought into the clock domain by a two-stage synchronizer. One further register remembers the previous synchronized value so that edges can be detected. A detected event sets the pin's status bit. Software clears status with a write-one-to-clear access.

Writes come from a register decoder that sits outside this block. That decoder presents a write strobe, a write kind, a port index and a data word. A sense write programs all eight pins of the addressed port at once. The data word is three bytes. The low byte selects high/rising polarity. The middle byte selects edge sensing. The high byte selects both-edge sensing. The bank request is the OR, over all 32 pins, of status AND enable.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, all status bits, all enable bits and the bank request are 0. Reset also programs every pin for level-low sensing and clears the synchronizer history to low.
- R2: A sense write (kind 1) to port p sets the mode of pin b of that port from data bit b (polarity), data bit 8+b (edge select) and data bit 16+b (both edges). Written as {bit 16+b, bit 8+b, bit b}: rising = 011, falling = 010, both = 110 (111 also means both), level-high = 001, level-low = 000.
- R3: In rising mode, a low-to-high change of the synchronized pin sets its status bit. A high-to-low change does not.
- R4: In falling mode, a high-to-low change sets status. A low-to-high change does not.
- R5: In both-edge mode, either change sets status.
- R6: In level modes, status is forced to 1 while the synchronized level is active (high for level-high, low for level-low). While it is active, a clear has no effect. Once the level is inactive, status holds until it is cleared.
- R7: A clear write (kind 2) to port p clears status bit b of that port for every data bit b that is 1. Status bits whose data bit is 0 are left unchanged.
- R8: When an event on a pin and a clear of that same pin fall in the same cycle, the event wins and the status bit stays 1.
- R9: irq_o is 1 exactly when at least one pin of any port has both its status bit and its enable bit set. Enable bits mask only the request, never the status.
- R10: A pin value first captured at clock edge k changes status at edge k+2. The status is therefore visible after the third edge following the moment the input changes.
- R11: An enable write (kind 0) loads data[7:0] as the enable bits of the addressed port only. Kind 3, and writes while wr_en is 0, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the shared register decoder |
| wr_kind | input | 2 | 0 enable, 1 sense, 2 clear, 3 none |
| wr_port | input | 2 | Port index addressed by the write |
| wr_data | input | 24 | Write data; sense uses all three bytes, the other kinds use the low byte |
| pin_in | input | 32 | Asynchronous pin levels, pin b of port p at bit 8*p+b |
| status_o | output | 32 | Status bits, same bit order as pin_in |
| enable_o | output | 32 | Enable bits, same bit order as pin_in |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The bound checker watches four things on every cycle. The request must equal the OR of status AND enable taken at the ports. A status bit may only fall after a clear that hits that bit. Enables may only change after an enable write. Everything must be quiet straight after reset. The mode-specific detection cannot be seen from those port-level relations and is shown only by the bench's scenarios. This covers edge polarity, the both-edge and level decodes, level stickiness, the two-stage latency and the event-beats-clear priority. The bench also compares every output each cycle against its behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        WR_ENABLE = 2'd0,
        WR_SENSE  = 2'd1,
        WR_CLEAR  = 2'd2,
        WR_NONE   = 2'd3
    } wr_kind_e;

    // per-pin sense selection as three independent flags
    typedef struct packed {
        logic both;      // any edge when edge_sel is set
        logic edge_sel;  // 1: edge sensing, 0: level sensing
        logic pol;       // high / rising when set
    } sense_t;

    // Returns 1 when the pin should set its status this cycle.
    function automatic logic sense_fire(input sense_t s, input logic cur, input logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (s.edge_sel) begin
            if (s.both)
                return rise | fall;
            else
                return s.pol ? rise : fall;
        end
        return s.pol ? cur : ~cur;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_async,
    input  sense_t sense,
    input  logic   clr,
    output logic   status
);
    logic cur_s;
    logic prev_q;
    logic status_q;
    logic fire;

    gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_async),
        .q   (cur_s)
    );

    assign fire = sense_fire(sense, cur_s, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            prev_q <= cur_s;
            if (fire)
                status_q <= 1'b1;   // a new event outranks a clear
            else if (clr)
                status_q <= 1'b0;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int PORT_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PORT_ID     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [3*PINS-1:0] wr_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   status_o,
    output logic [PINS-1:0]   enable_o,
    output logic              pend_o
);
    localparam int SW = 3 * PINS;

    logic              hit;
    wr_kind_e          kind;
    logic [PINS-1:0]   enable_q;
    logic [SW-1:0]     sense_q;
    logic [PINS-1:0]   clr_vec;

    assign kind    = wr_kind_e'(wr_kind);
    assign hit     = wr_en && (wr_port == PORT_W'(PORT_ID));
    assign clr_vec = (hit && kind == WR_CLEAR) ? wr_data[PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            sense_q  <= '0;
        end else if (hit) begin
            if (kind == WR_ENABLE) enable_q <= wr_data[PINS-1:0];
            if (kind == WR_SENSE)  sense_q  <= wr_data;
        end
    end

    generate
        for (genvar b = 0; b < PINS; b++) begin : g_pin
            sense_t s;
            assign s.both     = sense_q[2*PINS + b];
            assign s.edge_sel = sense_q[PINS + b];
            assign s.pol      = sense_q[b];

            gpio_irq_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
                .clk       (clk),
                .rst       (rst),
                .pin_async (pin_in[b]),
                .sense     (s),
                .clr       (clr_vec[b]),
                .status    (status_o[b])
            );
        end
    endgenerate

    assign enable_o = enable_q;
    assign pend_o   = |(status_o & enable_q);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int N_PORTS     = 4,
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    parameter int DATA_W      = 3 * PINS,
    parameter int TOTAL       = N_PORTS * PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TOTAL-1:0]  pin_in,
    output logic [TOTAL-1:0]  status_o,
    output logic [TOTAL-1:0]  enable_o,
    output logic              irq_o
);
    logic [N_PORTS-1:0] pend;

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            gpio_irq_port #(
                .PINS        (PINS),
                .PORT_W      (PORT_W),
                .SYNC_STAGES (SYNC_STAGES),
                .PORT_ID     (p)
            ) u_port (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_en),
                .wr_kind  (wr_kind),
                .wr_port  (wr_port),
                .wr_data  (wr_data),
                .pin_in   (pin_in[p*PINS +: PINS]),
                .status_o (status_o[p*PINS +: PINS]),
                .enable_o (enable_o[p*PINS +: PINS]),
                .pend_o   (pend[p])
            );
        end
    endgenerate

    assign irq_o = |pend;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int N_PORTS = 4,
    parameter int PINS    = 8,
    parameter int PORT_W  = 2,
    parameter int DATA_W  = 24,
    parameter int TOTAL   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_kind,
    input logic [PORT_W-1:0] wr_port,
    input logic [DATA_W-1:0] wr_data,
    input logic [TOTAL-1:0]  status_o,
    input logic [TOTAL-1:0]  enable_o,
    input logic              irq_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_o == '0 && enable_o == '0 && !irq_o));

    assert_request_or_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|(status_o & enable_o)));

    assert_enable_only_by_write_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(enable_o) |-> $past(wr_en && wr_kind == 2'd0));

    generate
        for (genvar i = 0; i < TOTAL; i++) begin : g_bit
            localparam int P = i / PINS;
            localparam int B = i % PINS;
            assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
                $fell(status_o[i]) |->
                    $past(wr_en && wr_kind == 2'd2 && wr_port == PORT_W'(P) && wr_data[B]));
        end
    endgenerate
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .N_PORTS (N_PORTS),
    .PINS    (PINS),
    .PORT_W  (PORT_W),
    .DATA_W  (DATA_W),
    .TOTAL   (TOTAL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .status_o (status_o),
    .enable_o (enable_o),
    .irq_o    (irq_o)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    localparam int NP = 4;
    localparam int PN = 8;
    localparam int NT = NP * PN;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'd3;
    logic [1:0]    wr_port = '0;
    logic [23:0]   wr_data = '0;
    logic [NT-1:0] pin_in = '0;
    logic [NT-1:0] status_o;
    logic [NT-1:0] enable_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_port(wr_port),
        .wr_data(wr_data), .pin_in(pin_in), .status_o(status_o),
        .enable_o(enable_o), .irq_o(irq_o)
    );

    // behavioural reference
    logic [NT-1:0] m_s1, m_s2, m_pv, m_sta, m_en, nsta;
    logic [23:0]   m_sense [NP];
    logic          fire, clr, pol, edg, bth;
    int            pp, bb;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_pv = '0; m_sta = '0; m_en = '0;
            for (int k = 0; k < NP; k++) m_sense[k] = '0;
        end else begin
            for (int i = 0; i < NT; i++) begin
                pp  = i / PN; bb = i % PN;
                pol = m_sense[pp][bb]; edg = m_sense[pp][8+bb]; bth = m_sense[pp][16+bb];
                if (edg)
                    fire = bth ? (m_s2[i] != m_pv[i])
                               : (pol ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]));
                else
                    fire = pol ? m_s2[i] : !m_s2[i];
                clr = wr_en && wr_kind == 2'd2 && wr_port == pp[1:0] && wr_data[bb];
                nsta[i] = fire ? 1'b1 : (clr ? 1'b0 : m_sta[i]);
            end
            m_sta = nsta;
            m_pv  = m_s2;
            m_s2  = m_s1;
            m_s1  = pin_in;
            if (wr_en && wr_kind == 2'd0) m_en[wr_port*PN +: PN] = wr_data[7:0];
            if (wr_en && wr_kind == 2'd1) m_sense[wr_port] = wr_data;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("R10 model status", 64'(status_o), 64'(m_sta));
            check("R11 model enable", 64'(enable_o), 64'(m_en));
            check("R9 model request", 64'(irq_o), 64'(|(m_sta & m_en)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] k, input logic [1:0] p, input logic [23:0] d);
        wr_en = 1'b1; wr_kind = k; wr_port = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3; wr_data = '0;
    endtask

    initial begin
        tick(3);
        check("R1 reset status", 64'(status_o), 64'd0);
        check("R1 reset enable", 64'(enable_o), 64'd0);
        check("R1 reset request", 64'(irq_o), 64'd0);
        rst = 1'b0;
        tick(1);
        check("R1 first cycle after reset enable", 64'(enable_o), 64'd0);
        for (int p = 0; p < NP; p++) wr(2'd1, p[1:0], 24'h00FFFF);
        for (int p = 0; p < NP; p++) wr(2'd2, p[1:0], 24'h0000FF);
        check("R7 all cleared", 64'(status_o), 64'd0);

        // rising edge and latency
        pin_in[0] = 1'b1;
        tick(1); check("R10 one edge", 64'(status_o[0]), 64'd0);
        tick(1); check("R10 two edges", 64'(status_o[0]), 64'd0);
        tick(1); check("R3 R10 rise sets status", 64'(status_o[0]), 64'd1);

        // selective clear
        pin_in[1] = 1'b1; tick(3);
        wr(2'd2, 2'd0, 24'h000001);
        check("R7 cleared bit", 64'(status_o[0]), 64'd0);
        check("R7 untouched bit", 64'(status_o[1]), 64'd1);

        // event and clear together
        pin_in[2] = 1'b1; tick(2);
        wr(2'd2, 2'd0, 24'h000004);
        check("R8 event beats clear", 64'(status_o[2]), 64'd1);

        // falling
        wr(2'd1, 2'd1, 24'h00FF00);
        pin_in[8] = 1'b1; tick(3);
        check("R4 rise ignored", 64'(status_o[8]), 64'd0);
        pin_in[8] = 1'b0; tick(3);
        check("R4 fall sets", 64'(status_o[8]), 64'd1);

        // both edges
        wr(2'd1, 2'd2, 24'hFFFF00);
        pin_in[16] = 1'b1; tick(3);
        check("R5 rise sets", 64'(status_o[16]), 64'd1);
        wr(2'd2, 2'd2, 24'h0000FF);
        check("R5 cleared", 64'(status_o[16]), 64'd0);
        pin_in[16] = 1'b0; tick(3);
        check("R5 fall sets", 64'(status_o[16]), 64'd1);
        wr(2'd1, 2'd2, 24'hFFFFFF);
        wr(2'd2, 2'd2, 24'h0000FF);
        pin_in[16] = 1'b1; tick(3);
        check("R5 code 111 acts as both", 64'(status_o[16]), 64'd1);

        // level modes
        wr(2'd1, 2'd3, 24'h0000FF);
        pin_in[24] = 1'b1; tick(3);
        check("R6 level high sets", 64'(status_o[24]), 64'd1);
        wr(2'd2, 2'd3, 24'h0000FF);
        check("R6 clear ignored while active", 64'(status_o[24]), 64'd1);
        pin_in[24] = 1'b0; tick(3);
        check("R6 holds when inactive", 64'(status_o[24]), 64'd1);
        wr(2'd2, 2'd3, 24'h0000FF);
        check("R6 clear once inactive", 64'(status_o[24]), 64'd0);
        wr(2'd1, 2'd3, 24'h000000);
        tick(1);
        check("R6 level low sets", 64'(status_o[25]), 64'd1);

        // request and enables
        wr(2'd0, 2'd0, 24'h000001);
        check("R9 enabled bit without status", 64'(irq_o), 64'd0);
        wr(2'd0, 2'd0, 24'h000004);
        check("R9 enabled status raises request", 64'(irq_o), 64'd1);
        wr(2'd0, 2'd1, 24'h0000FF);
        check("R11 other port enable kept", 64'(enable_o[7:0]), 64'h04);
        wr(2'd2, 2'd0, 24'h000004);
        wr(2'd2, 2'd1, 24'h0000FF);
        check("R9 request drops", 64'(irq_o), 64'd0);
        check("R9 status kept under mask", 64'(status_o[1]), 64'd1);
        wr(2'd3, 2'd0, 24'hFFFFFF);
        check("R11 kind 3 no effect", 64'(enable_o[7:0]), 64'h04);

        // field layout of one pin
        wr(2'd1, 2'd0, 24'h002020);
        wr(2'd2, 2'd0, 24'h000020);
        pin_in[5] = 1'b1; tick(3);
        check("R2 pin5 rising fields", 64'(status_o[5]), 64'd1);
        check("R2 pin6 level low", 64'(status_o[6]), 64'd1);

        tick(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule